// File: doc/BRIEF.md
# Programmable Interval Timer Host Register Interface

This block sits between an 8-bit host bus and three 16-bit timer channels. The host selects a channel or the shared control port with a 2-bit address, qualifies every access with an active-low chip select, and uses active-low read and write strobes. The bus is synchronous to `clk`: every cycle in which chip select and a strobe are both low is one access. Each channel keeps its own configuration, which holds its byte format, a 3-bit mode field for downstream counting logic and a binary/BCD flag. Each channel also keeps its own write and read byte pointers and its own latch holding register.

The host writes a control word to the shared port and names the target channel inside it. It then writes the initial count as one or two bytes, in the format that control word selected. Each channel's down-counter loads the assembled count and steps once per cycle while its clock-enable is high. It counts in binary or in BCD. Count values are read back one byte at a time, either live or from a snapshot frozen by a latch command.

Top module: `pit_host_if`

## Requirements
- R1: After reset every channel reports mode 0 and binary counting on `mode_o`/`bcd_o`, and a read of any channel returns 8'h00.
- R2: While `cs_n` is high, a low `wr_n` or `rd_n` has no effect: no configuration changes, no count loads, and `rdata` stays 8'h00.
- R3: A write at address 2'b11 is a control word. Bits 7:6 name the channel (00/01/10 = channel 0/1/2). Bits 5:4 give the format (00 latch, 01 low byte only, 10 high byte only, 11 low then high). Bits 3:1 give the mode and bit 0 selects BCD. Only the named channel changes. A word with bits 7:6 = 11 changes nothing.
- R4: A read at address 2'b11 returns 8'h00 and does not move any channel's read pointer.
- R5: Count bytes written to a channel that has not yet received a format-setting control word are ignored.
- R6: In low-only format one byte loads the count as {8'h00, byte}. In high-only format one byte loads it as {byte, 8'h00}. A read returns the low or high count byte respectively.
- R7: In low-then-high format the count loads only when the second byte arrives. Each channel keeps its own write pointer, so two-byte writes to different channels may be interleaved.
- R8: Writing count bytes never changes a channel's mode field or BCD flag.
- R9: Once loaded, a channel's count drops by one on every cycle its `cnt_en` bit is high, wrapping from 16'h0000 to 16'hFFFF in binary. The count holds while `cnt_en` is low.
- R10: In BCD the count decrements as four decimal digits and wraps from 16'h0000 to 16'h9999.
- R11: A latch command (format 00) freezes the channel's count. Reads return the frozen value in the channel's format until its last byte is read, and then return the live count. A second latch command before the frozen value is fully read is ignored.
- R12: In low-then-high format successive reads return the low byte, then the high byte. A format-setting control word returns both that channel's read and write pointers to the low byte and drops any held latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select qualifying both strobes |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 00/01/10 channel 0/1/2, 11 control port |
| wdata | input | 8 | Write data byte |
| cnt_en | input | 3 | Per-channel count enable, bit i for channel i |
| rdata | output | 8 | Read data, valid during the read cycle |
| mode_o | output | 9 | Stored mode fields, channel i at bits 3i+2:3i |
| bcd_o | output | 3 | Per-channel BCD flag |

## Verification
Every cycle, the bound checker confirms three things. No access with chip select high alters configuration or loads a count. A count-byte write never disturbs the mode outputs. A control-port read drives zero. It also confirms that a loaded count either holds or moves exactly when its enable says so, and that BCD counts keep decimal digits. Byte assembly for each format, interleaved two-byte writes, exact decrement and wrap values, and the latch snapshot lifetime depend on sequences of accesses. The bench scenarios show these by reading the counts back through the bus.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int BW  = 8;
  localparam int MW  = 3;
  localparam int NDIG = CW / 4;

  typedef enum logic [1:0] {
    FMT_LATCH = 2'b00,
    FMT_LO    = 2'b01,
    FMT_HI    = 2'b10,
    FMT_LOHI  = 2'b11
  } fmt_e;

  typedef struct packed {
    fmt_e          fmt;
    logic [MW-1:0] mode;
    logic          bcd;
  } chan_cfg_t;

  // Decimal decrement over NDIG digits, borrowing through zeros.
  function automatic logic [CW-1:0] bcd_dec(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int d = 0; d < NDIG; d++) begin
      if (borrow) begin
        if (v[d*4 +: 4] == 4'd0) begin
          r[d*4 +: 4] = 4'd9;
        end else begin
          r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] v, input logic bcd);
    return bcd ? bcd_dec(v) : v - CW'(1);
  endfunction

  // Initial count built from the arriving byte and the staged low byte.
  function automatic logic [CW-1:0] assemble(input fmt_e f, input logic [BW-1:0] stage,
                                             input logic [BW-1:0] b);
    case (f)
      FMT_LO:   return {{BW{1'b0}}, b};
      FMT_HI:   return {b, {BW{1'b0}}};
      FMT_LOHI: return {b, stage};
      default:  return '0;
    endcase
  endfunction

  function automatic logic [BW-1:0] pick_byte(input fmt_e f, input logic [CW-1:0] v,
                                              input logic hi_next);
    case (f)
      FMT_LO:   return v[BW-1:0];
      FMT_HI:   return v[CW-1:BW];
      FMT_LOHI: return hi_next ? v[CW-1:BW] : v[BW-1:0];
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/pit_bus_dec.sv
module pit_bus_dec import pit_pkg::*; (
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [1:0]     addr,
  input  logic [1:0]     cw_sel,
  output logic [NCH-1:0] ch_wr,
  output logic [NCH-1:0] ch_rd,
  output logic [NCH-1:0] cw_hit
);
  logic wr_acc, rd_acc, ctl_port;

  assign wr_acc   = !cs_n && !wr_n;
  assign rd_acc   = !cs_n && !rd_n && wr_n;
  assign ctl_port = (addr == 2'b11);

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ch_wr[i]  = wr_acc && (addr == 2'(i));
    assign ch_rd[i]  = rd_acc && (addr == 2'(i));
    assign cw_hit[i] = wr_acc && ctl_port && (cw_sel == 2'(i));
  end
endmodule

// File: rtl/pit_downcnt.sv
module pit_downcnt import pit_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  input  logic          bcd,
  output logic [CW-1:0] count,
  output logic          armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (load) begin
      count <= load_val;
      armed <= 1'b1;
    end else if (en && armed) begin
      count <= next_count(count, bcd);
    end
  end
endmodule

// File: rtl/pit_chan.sv
module pit_chan import pit_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_wr,
  input  logic [5:0]    cw_field,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [BW-1:0] wbyte,
  input  logic          cnt_en,
  output logic [BW-1:0] rbyte,
  output chan_cfg_t     cfg,
  output logic [CW-1:0] count,
  output logic          armed,
  output logic          load
);
  logic          wr_hi, rd_hi, latched;
  logic [BW-1:0] lo_stage;
  logic [CW-1:0] hold, src;
  logic          latch_cmd, mode_cmd, read_last, two_byte, programmed;

  assign two_byte   = (cfg.fmt == FMT_LOHI);
  assign programmed = (cfg.fmt != FMT_LATCH);
  assign latch_cmd  = cw_wr && (cw_field[5:4] == 2'b00);
  assign mode_cmd   = cw_wr && (cw_field[5:4] != 2'b00);
  assign load       = data_wr && programmed && (!two_byte || wr_hi);
  assign read_last  = data_rd && (!two_byte || rd_hi);
  assign src        = latched ? hold : count;
  assign rbyte      = pick_byte(cfg.fmt, src, rd_hi);

  pit_downcnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (assemble(cfg.fmt, lo_stage, wbyte)),
    .en       (cnt_en),
    .bcd      (cfg.bcd),
    .count    (count),
    .armed    (armed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '{fmt: FMT_LATCH, mode: '0, bcd: 1'b0};
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      latched  <= 1'b0;
      lo_stage <= '0;
      hold     <= '0;
    end else if (mode_cmd) begin
      cfg     <= '{fmt: fmt_e'(cw_field[5:4]), mode: cw_field[3:1], bcd: cw_field[0]};
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (latch_cmd && !latched) begin
        latched <= 1'b1;
        hold    <= count;
      end else if (read_last) begin
        latched <= 1'b0;
      end
      if (data_wr && two_byte) begin
        wr_hi <= !wr_hi;
        if (!wr_hi) lo_stage <= wbyte;
      end
      if (data_rd && two_byte) rd_hi <= !rd_hi;
    end
  end
endmodule

// File: rtl/pit_host_if.sv
module pit_host_if import pit_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BW-1:0]     wdata,
  input  logic [NCH-1:0]    cnt_en,
  output logic [BW-1:0]     rdata,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH-1:0]    bcd_o
);
  logic [NCH-1:0]         ch_wr, ch_rd, cw_hit;
  logic [NCH-1:0]         ch_load, ch_armed;
  logic [NCH-1:0][CW-1:0] ch_count;
  logic [NCH-1:0][1:0]    ch_fmt;
  logic [NCH-1:0][BW-1:0] ch_rbyte;
  chan_cfg_t              ch_cfg [NCH];

  pit_bus_dec u_dec (
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .cw_sel (wdata[7:6]),
    .ch_wr  (ch_wr),
    .ch_rd  (ch_rd),
    .cw_hit (cw_hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pit_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cw_wr    (cw_hit[i]),
      .cw_field (wdata[5:0]),
      .data_wr  (ch_wr[i]),
      .data_rd  (ch_rd[i]),
      .wbyte    (wdata),
      .cnt_en   (cnt_en[i]),
      .rbyte    (ch_rbyte[i]),
      .cfg      (ch_cfg[i]),
      .count    (ch_count[i]),
      .armed    (ch_armed[i]),
      .load     (ch_load[i])
    );
    assign mode_o[MW*i +: MW] = ch_cfg[i].mode;
    assign bcd_o[i]           = ch_cfg[i].bcd;
    assign ch_fmt[i]          = ch_cfg[i].fmt;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_rd[i]) rdata = ch_rbyte[i];
    end
  end
endmodule

// File: rtl/pit_host_if_chk.sv
module pit_host_if_chk import pit_pkg::*; (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   rd_n,
  input logic                   wr_n,
  input logic [1:0]             addr,
  input logic [NCH-1:0]         cnt_en,
  input logic [BW-1:0]          rdata,
  input logic [NCH*MW-1:0]      mode_o,
  input logic [NCH-1:0]         bcd_o,
  input logic [NCH-1:0]         ch_load,
  input logic [NCH-1:0]         ch_armed,
  input logic [NCH-1:0][CW-1:0] ch_count,
  input logic [NCH-1:0][1:0]    ch_fmt
);
  function automatic logic digits_ok(input logic [CW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < NDIG; d++) if (v[d*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  assert_cs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(mode_o) && $stable(bcd_o)));

  assert_cs_noload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ch_load == '0));

  assert_ctrl_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && wr_n && addr == 2'b11) |-> (rdata == '0));

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_n && addr != 2'b11) |=> ($stable(mode_o) && $stable(bcd_o)));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_load_needs_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> (ch_fmt[i] != 2'b00));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en[i] && ch_armed[i] && !ch_load[i]) |=> (ch_count[i] != $past(ch_count[i])));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((!cnt_en[i] || !ch_armed[i]) && !ch_load[i]) |=> $stable(ch_count[i]));

    assert_bcd_digits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bcd_o[i] && digits_ok(ch_count[i]) && !ch_load[i]) |=> digits_ok(ch_count[i]));
  end
endmodule

bind pit_host_if pit_host_if_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .cnt_en   (cnt_en),
  .rdata    (rdata),
  .mode_o   (mode_o),
  .bcd_o    (bcd_o),
  .ch_load  (ch_load),
  .ch_armed (ch_armed),
  .ch_count (ch_count),
  .ch_fmt   (ch_fmt)
);

// File: tb/tb_pit_host_if.sv
module tb_pit_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [2:0] cnt_en = 3'b000;
  logic [7:0] rdata;
  logic [8:0] mode_o;
  logic [2:0] bcd_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pit_host_if dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .cnt_en(cnt_en), .rdata(rdata),
    .mode_o(mode_o), .bcd_o(bcd_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic run_en(input int ch, input int n);
    @(negedge clk);
    cnt_en[ch] = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en[ch] = 1'b0;
  endtask

  task automatic t_reset;
    check(mode_o == 9'h0, "R1 mode", mode_o, 0);
    check(bcd_o == 3'b0, "R1 bcd", bcd_o, 0);
    expect_rd(2'd0, 8'h00, "R1 read");
  endtask

  task automatic t_cs_gate;
    logic [7:0] v;
    bus_wr(2'b11, 8'h3E, 1'b1);
    check(mode_o == 9'h0, "R2 write ignored", mode_o, 0);
    bus_rd(2'd0, v, 1'b1);
    check(v == 8'h00, "R2 read ignored", v, 0);
  endtask

  task automatic t_ctrl_word;
    bus_wr(2'b11, 8'h7A);   // ch1, low-then-high, mode 5, binary
    check(mode_o == 9'(5 << 3), "R3 routed", mode_o, 5 << 3);
    bus_wr(2'b11, 8'hFF);   // select 11: no channel
    check(mode_o == 9'(5 << 3) && bcd_o == 3'b0, "R3 sel11", mode_o, 5 << 3);
  endtask

  task automatic t_unprog;
    bus_wr(2'd2, 8'h55);    // ch2 not yet configured
    bus_wr(2'b11, 8'h90);   // ch2, low only
    expect_rd(2'd2, 8'h00, "R5 ignored");
  endtask

  task automatic t_formats;
    bus_wr(2'd2, 8'h5A);
    expect_rd(2'd2, 8'h5A, "R6 low-only read");
    bus_wr(2'b11, 8'hB0);   // ch2 low-then-high
    expect_rd(2'd2, 8'h5A, "R6 lo load low");
    expect_rd(2'd2, 8'h00, "R6 lo load high zero");
    bus_wr(2'b11, 8'hA0);   // ch2 high only
    bus_wr(2'd2, 8'hC3);
    expect_rd(2'd2, 8'hC3, "R6 high-only read");
    bus_wr(2'b11, 8'hB0);
    expect_rd(2'd2, 8'h00, "R6 hi load low zero");
    expect_rd(2'd2, 8'hC3, "R6 hi load high");
  endtask

  task automatic t_interleave;
    bus_wr(2'b11, 8'h34);   // ch0 low-then-high, mode 2
    bus_wr(2'd0, 8'h34);
    bus_wr(2'd1, 8'h78);
    expect_rd(2'd0, 8'h00, "R7 no load after first byte lo");
    expect_rd(2'd0, 8'h00, "R7 no load after first byte hi");
    bus_wr(2'd1, 8'h56);
    bus_wr(2'd0, 8'h12);
    expect_rd(2'd0, 8'h34, "R7 ch0 low");
    expect_rd(2'd0, 8'h12, "R7 ch0 high");
    expect_rd(2'd1, 8'h78, "R7 ch1 low");
    expect_rd(2'd1, 8'h56, "R7 ch1 high");
    check(mode_o == 9'((5 << 3) | 2), "R8 modes kept", mode_o, (5 << 3) | 2);
  endtask

  task automatic t_ctrl_read;
    expect_rd(2'b11, 8'h00, "R4 control read");
    expect_rd(2'd0, 8'h34, "R4 pointer undisturbed lo");
    expect_rd(2'd0, 8'h12, "R4 pointer undisturbed hi");
  endtask

  task automatic t_count_bin;
    run_en(0, 5);
    expect_rd(2'd0, 8'h2F, "R9 step lo");
    expect_rd(2'd0, 8'h12, "R9 step hi");
    bus_wr(2'd0, 8'h01);
    bus_wr(2'd0, 8'h00);
    run_en(0, 2);
    expect_rd(2'd0, 8'hFF, "R9 wrap lo");
    expect_rd(2'd0, 8'hFF, "R9 wrap hi");
  endtask

  task automatic t_count_bcd;
    bus_wr(2'b11, 8'h71);   // ch1 low-then-high, mode 0, BCD
    check(bcd_o == 3'b010, "R3 bcd flag", bcd_o, 3'b010);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd1, 8'h10);
    run_en(1, 1);
    expect_rd(2'd1, 8'h99, "R10 borrow lo");
    expect_rd(2'd1, 8'h09, "R10 borrow hi");
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd1, 8'h00);
    run_en(1, 1);
    expect_rd(2'd1, 8'h99, "R10 wrap lo");
    expect_rd(2'd1, 8'h99, "R10 wrap hi");
  endtask

  task automatic t_latch;
    bus_wr(2'd0, 8'h21);
    bus_wr(2'd0, 8'h43);
    bus_wr(2'b11, 8'h00);   // latch ch0
    run_en(0, 3);
    expect_rd(2'd0, 8'h21, "R11 frozen lo");
    bus_wr(2'b11, 8'h00);   // ignored while held
    run_en(0, 2);
    expect_rd(2'd0, 8'h43, "R11 frozen hi");
    expect_rd(2'd0, 8'h1C, "R11 live lo");
    expect_rd(2'd0, 8'h43, "R11 live hi");
  endtask

  task automatic t_ptr_reset;
    expect_rd(2'd0, 8'h1C, "R12 first low");
    bus_wr(2'd0, 8'hAA);    // half a write, then reprogram
    bus_wr(2'b11, 8'h30);   // ch0 low-then-high, mode 0
    expect_rd(2'd0, 8'h1C, "R12 read ptr reset");
    expect_rd(2'd0, 8'h43, "R12 alternation");
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd0, 8'h22);
    expect_rd(2'd0, 8'h11, "R12 write ptr reset lo");
    expect_rd(2'd0, 8'h22, "R12 write ptr reset hi");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cs_gate();
    t_ctrl_word();
    t_unprog();
    t_formats();
    t_interleave();
    t_ctrl_read();
    t_count_bin();
    t_count_bcd();
    t_latch();
    t_ptr_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule